// File: doc/BRIEF.md
# I2C Bit-Rate Tick Generator

This block turns the system clock into the timing tick an I2C master's bit engine uses to place the SCL phases. The tick runs at ten times the SCL rate. A one-byte rate setting holds two divisor fields. A 4-bit linear field M divides by M+1. A 3-bit exponent field N then divides by a power of two. The fixed factor of ten comes from the tick-to-SCL ratio. In the default build, SCL = f_clk / (10 · (M+1) · 2^(N+1)). With the `ALT_POW` parameter set, the exponent stage drops its extra factor of two, and SCL = f_clk / (10 · (M+1) · 2^N).

The rate byte is written through a simple write strobe. A new value is applied only at a tick boundary, so no shortened tick is produced. While the controller is disabled, the divider counters hold at zero. A soft reset input returns the block to its power-up setting, the byte 0x44.

A helper engine finds a rate byte for a target frequency. Given a requested SCL frequency in Hz, it walks all 128 (M, N) pairs, one pair per clock. It reports the pair that gives the fastest SCL rate not above the request.

Top module: `i2c_rate_gen`

## Requirements
- R1: After a synchronous reset (`rst_n` low) or a one-cycle `soft_rst`, the following hold. `baud_q` reads 0x44, meaning M=8 and N=4. `tick` is low. The search engine is idle, with `srch_baud` = 0x44 and `srch_hz` = 0. In the default build, the first tick period after enabling is 288 clocks.
- R2: In the rate byte, bits 6:3 are M and bits 2:0 are N. Bit 7 of a write is discarded and always reads back as 0. For example, writing 0xFB gives `baud_q` = 0x7B and a default-mode period of 256 clocks.
- R3: In the default build, consecutive rising edges of `tick` are exactly (M+1)·2^(N+1) clocks apart. For example, 0x44 gives 288, 0x09 gives 8 and 0x00 gives 2.
- R4: For any period of two or more clocks, `tick` is high for exactly one clock per period.
- R5: While `enable` is low, `tick` stays low and the counters are cleared. When `enable` is first sampled high at a clock edge, the first tick is high in the P-th cycle after that edge, where P is the period.
- R6: A rate byte written while the divider runs does not change the period already in progress. That period completes at the old length, and every following period uses the new value.
- R7: A rate byte written while `enable` is low applies to the very first period after `enable` rises.
- R8: The search is started by `srch_go`. Exactly 128 clocks after the edge that samples `srch_go`, `srch_done` is high for one clock. `srch_baud` and `srch_hz` then hold the pair with the highest integer rate f_clk / (10·(M+1)·2^(N+1)) that does not exceed `srch_req`. Pairs are visited with N outer (0..7) and M inner (0..15). On equal rates the earlier pair is kept; for example, a request of 2,500,000 at 100 MHz yields 0x08. `srch_go` is ignored while `srch_busy` is high.
- R9: If no pair gives a rate at or below the request, the search reports `srch_baud` = 0x44 and `srch_hz` = 0.
- R10: With `ALT_POW` = 1, the period is (M+1)·2^N clocks, and the search uses the rate f_clk / (10·(M+1)·2^N).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| soft_rst | input | 1 | Synchronous soft reset to the power-up state |
| enable | input | 1 | Controller enable; counters hold at zero while low |
| baud_we | input | 1 | Write strobe for the rate byte |
| baud_wdata | input | 8 | Rate byte to write (M in 6:3, N in 2:0) |
| baud_q | output | 8 | Currently programmed rate byte |
| tick | output | 1 | One-clock pulse at ten times the SCL rate |
| srch_go | input | 1 | Starts a rate search |
| srch_req | input | 32 | Requested SCL frequency in Hz |
| srch_busy | output | 1 | Search in progress |
| srch_done | output | 1 | One-clock pulse when the search result is valid |
| srch_baud | output | 8 | Best rate byte found |
| srch_hz | output | 32 | SCL frequency of the best rate byte, 0 if none fits |

## Verification
The tick output is registered. A tick period that starts at the edge sampling `enable`, or at the previous tick, ends with `tick` high after the P-th following edge. The monitor therefore counts rising edges with the enable sampled high, and compares that count with the queued period at the falling edge where `tick` is seen. A write while running is expected to affect only the period after the one in progress, so the driver queues the old period first and then the new ones. A search result is due 128 edges after the edge that samples `srch_go`. The search monitor counts edges from that edge and compares both the timing and the result at the falling edge where `srch_done` is seen.

// File: rtl/i2c_rate_pkg.sv
// Package: shared field widths, the power-up rate byte and the period
// formula used by both the divider and the search table.
package i2c_rate_pkg;

    localparam int BR_M_W    = 4;                 // linear divisor field width
    localparam int BR_N_W    = 3;                 // exponent field width
    localparam int BR_BAUD_W = BR_M_W + BR_N_W + 1;

    localparam logic [BR_BAUD_W-1:0] BR_RST_BAUD   = 8'h44;
    localparam logic [BR_BAUD_W-1:0] BR_FIELD_MASK = 8'h7F;

    // Clock cycles per tick for a given (M, N) and exponent offset.
    function automatic int unsigned br_period(input int m, input int n, input int shift);
        return int'(m + 1) * (1 << (n + shift));
    endfunction

endpackage

// File: rtl/i2c_rate_reg.sv
// Rate byte holder.
// Keeps the programmed byte and the byte in use by the divider. The byte
// in use is refreshed from the programmed one at every tick boundary and
// continuously while the divider is disabled.
// Assumes: wrap is a one-cycle pulse from the divider at period end.
module i2c_rate_reg
    import i2c_rate_pkg::*;
#(
    parameter int M_W    = BR_M_W,
    parameter int N_W    = BR_N_W,
    localparam int BAUD_W = M_W + N_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              enable,
    input  logic              wrap,
    input  logic              we,
    input  logic [BAUD_W-1:0] wdata,
    output logic [BAUD_W-1:0] baud_q,
    output logic [M_W-1:0]    m_act,
    output logic [N_W-1:0]    n_act
);

    localparam logic [BAUD_W-1:0] RST_B  = BAUD_W'(BR_RST_BAUD);
    localparam logic [BAUD_W-1:0] MASK_B = BAUD_W'(BR_FIELD_MASK);

    logic [BAUD_W-1:0] prog_q;
    logic [BAUD_W-1:0] act_q;

    // Programmed byte: software write, top bit discarded.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst)
            prog_q <= RST_B;
        else if (we)
            prog_q <= wdata & MASK_B;
    end

    // Byte in use: reloads only at a period boundary or while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst)
            act_q <= RST_B;
        else if (!enable || wrap)
            act_q <= prog_q;
    end

    assign baud_q = prog_q;
    assign m_act  = act_q[N_W +: M_W];
    assign n_act  = act_q[N_W-1:0];

    p_pad_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        baud_q[BAUD_W-1] == 1'b0);

    p_act_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !wrap && !soft_rst) |=> $stable(act_q));

    p_soft_val_r1: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (baud_q == RST_B && act_q == RST_B));

endmodule

// File: rtl/i2c_rate_div.sv
// Two-stage tick divider.
// Stage one counts 0..M on every enabled clock. Stage two counts stage-one
// wraps up to 2^(N+SHIFT)-1. The tick is registered and lasts one clock.
// Assumes: m_act/n_act only change when both counters are at zero.
module i2c_rate_div
    import i2c_rate_pkg::*;
#(
    parameter int M_W   = BR_M_W,
    parameter int N_W   = BR_N_W,
    parameter int SHIFT = 1,
    localparam int EXP_W = (1 << N_W) - 1 + SHIFT
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           soft_rst,
    input  logic           enable,
    input  logic [M_W-1:0] m_act,
    input  logic [N_W-1:0] n_act,
    output logic           wrap,
    output logic           tick
);

    localparam logic [EXP_W:0] ONE = 1;

    logic [M_W-1:0]   lin_q;
    logic [EXP_W-1:0] exp_q;
    logic [EXP_W:0]   span;
    logic [EXP_W-1:0] exp_lim;
    logic             lin_end;

    // Exponent stage limit: 2^(N+SHIFT) - 1.
    always_comb begin
        span    = ONE << (32'(n_act) + 32'(SHIFT));
        exp_lim = EXP_W'(span - ONE);
    end

    assign lin_end = (lin_q == m_act);
    assign wrap    = enable && lin_end && (exp_q == exp_lim);

    // Counter cascade, cleared while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst || !enable) begin
            lin_q <= '0;
            exp_q <= '0;
        end else if (lin_end) begin
            lin_q <= '0;
            exp_q <= (exp_q == exp_lim) ? '0 : exp_q + 1'b1;
        end else begin
            lin_q <= lin_q + 1'b1;
        end
    end

    // Registered one-clock tick at period end.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst)
            tick <= 1'b0;
        else
            tick <= wrap;
    end

    p_lin_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        lin_q <= m_act);

    p_exp_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        exp_q <= exp_lim);

    p_tick_needs_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> $past(enable));

    p_idle_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (lin_q == '0 && exp_q == '0 && !tick));

endmodule

// File: rtl/i2c_rate_search.sv
// Rate search helper.
// Walks every (M, N) pair, N outer and M inner, one pair per clock. It keeps
// the pair with the highest rate not above the request; a strict compare
// keeps the earlier pair on ties. Candidate rates come from a table that
// is computed at elaboration, so no run-time divider is needed.
// Assumes: srch results are valid only while done is high and afterwards.
module i2c_rate_search
    import i2c_rate_pkg::*;
#(
    parameter int unsigned CLK_HZ = 100_000_000,
    parameter int          M_W    = BR_M_W,
    parameter int          N_W    = BR_N_W,
    parameter int          SHIFT  = 1,
    parameter int          RATE_W = 32,
    localparam int IDX_W  = M_W + N_W,
    localparam int PAIRS  = 1 << IDX_W,
    localparam int BAUD_W = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              go,
    input  logic [RATE_W-1:0] req,
    output logic              busy,
    output logic              done,
    output logic [BAUD_W-1:0] best_baud,
    output logic [RATE_W-1:0] best_hz
);

    localparam logic [BAUD_W-1:0] RST_B = BAUD_W'(BR_RST_BAUD);
    localparam logic [IDX_W-1:0]  LAST  = '1;

    logic [RATE_W-1:0] rate_tbl [PAIRS];
    logic [IDX_W-1:0]  idx_q;
    logic [RATE_W-1:0] req_q;
    logic [RATE_W-1:0] cand;
    logic              better;

    // Elaboration-time rate per pair; index = {N, M}.
    for (genvar gi = 0; gi < PAIRS; gi++) begin : g_rate
        localparam int MI = gi % (1 << M_W);
        localparam int NI = gi / (1 << M_W);
        localparam int unsigned DIVV = 10 * br_period(MI, NI, SHIFT);
        assign rate_tbl[gi] = RATE_W'(CLK_HZ / DIVV);
    end

    assign cand   = rate_tbl[idx_q];
    assign better = (cand <= req_q) && (cand > best_hz);

    // Scan sequencer and best-candidate tracker.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            busy      <= 1'b0;
            done      <= 1'b0;
            idx_q     <= '0;
            req_q     <= '0;
            best_baud <= RST_B;
            best_hz   <= '0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (go) begin
                    busy      <= 1'b1;
                    idx_q     <= '0;
                    req_q     <= req;
                    best_baud <= RST_B;
                    best_hz   <= '0;
                end
            end else begin
                if (better) begin
                    best_hz   <= cand;
                    best_baud <= {1'b0, idx_q[M_W-1:0], idx_q[IDX_W-1:M_W]};
                end
                if (idx_q == LAST) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_busy_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !soft_rst) |=> (busy || done));

    p_go_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (go && !busy && !soft_rst) |=> (busy && best_hz == '0));

    p_fit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (best_hz <= req_q));

endmodule

// File: rtl/i2c_rate_gen.sv
// I2C bit-rate tick generator (top).
// Joins the rate byte holder, the two-stage divider and the search helper.
// ALT_POW selects the exponent offset: 0 divides by 2^(N+1), 1 by 2^N.
// Assumes: a single clock domain and a synchronous active-low reset.
module i2c_rate_gen
    import i2c_rate_pkg::*;
#(
    parameter int unsigned CLK_HZ  = 100_000_000,
    parameter bit          ALT_POW = 1'b0,
    parameter int          RATE_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              enable,
    input  logic              baud_we,
    input  logic [7:0]        baud_wdata,
    output logic [7:0]        baud_q,
    output logic              tick,
    input  logic              srch_go,
    input  logic [RATE_W-1:0] srch_req,
    output logic              srch_busy,
    output logic              srch_done,
    output logic [7:0]        srch_baud,
    output logic [RATE_W-1:0] srch_hz
);

    localparam int SHIFT = ALT_POW ? 0 : 1;

    logic [BR_M_W-1:0] m_act;
    logic [BR_N_W-1:0] n_act;
    logic              wrap;

    i2c_rate_reg #(
        .M_W (BR_M_W),
        .N_W (BR_N_W)
    ) u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .enable   (enable),
        .wrap     (wrap),
        .we       (baud_we),
        .wdata    (baud_wdata),
        .baud_q   (baud_q),
        .m_act    (m_act),
        .n_act    (n_act)
    );

    i2c_rate_div #(
        .M_W   (BR_M_W),
        .N_W   (BR_N_W),
        .SHIFT (SHIFT)
    ) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .enable   (enable),
        .m_act    (m_act),
        .n_act    (n_act),
        .wrap     (wrap),
        .tick     (tick)
    );

    i2c_rate_search #(
        .CLK_HZ (CLK_HZ),
        .M_W    (BR_M_W),
        .N_W    (BR_N_W),
        .SHIFT  (SHIFT),
        .RATE_W (RATE_W)
    ) u_search (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_rst  (soft_rst),
        .go        (srch_go),
        .req       (srch_req),
        .busy      (srch_busy),
        .done      (srch_done),
        .best_baud (srch_baud),
        .best_hz   (srch_hz)
    );

endmodule

// File: tb/i2c_rate_gen_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: drivers queue expected tick periods and search results;
// monitors pop and compare them when the design produces each result.
module i2c_rate_gen_tb;

    localparam int unsigned CLK_HZ = 100_000_000;

    typedef struct {
        int    p;
        string tag;
    } tick_exp_t;

    typedef struct {
        logic [7:0]  b;
        int unsigned hz;
        string       tag;
    } srch_exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst = 1'b0;
    logic        en = 1'b0;
    logic        we = 1'b0;
    logic [7:0]  wdata = '0;
    logic [7:0]  baud_q;
    logic        tick;
    logic        go = 1'b0;
    logic [31:0] req = '0;
    logic        busy, done;
    logic [7:0]  sbaud;
    logic [31:0] shz;

    logic        a_en = 1'b0;
    logic        a_we = 1'b0;
    logic [7:0]  a_wdata = '0;
    logic [7:0]  a_baud_q;
    logic        a_tick;
    logic        a_go = 1'b0;
    logic [31:0] a_req = '0;
    logic        a_busy, a_done;
    logic [7:0]  a_sbaud;
    logic [31:0] a_shz;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    tick_exp_t tq[$];
    tick_exp_t aq[$];
    srch_exp_t sq[$];
    int  tcnt = 0, acnt = 0, scnt = 0;
    bit  en_q = 1'b0, a_en_q = 1'b0, s_armed = 1'b0;

    always #2.5 clk = ~clk;

    i2c_rate_gen #(.CLK_HZ(CLK_HZ), .ALT_POW(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .enable(en),
        .baud_we(we), .baud_wdata(wdata), .baud_q(baud_q), .tick(tick),
        .srch_go(go), .srch_req(req), .srch_busy(busy), .srch_done(done),
        .srch_baud(sbaud), .srch_hz(shz)
    );

    i2c_rate_gen #(.CLK_HZ(CLK_HZ), .ALT_POW(1'b1)) u_alt (
        .clk(clk), .rst_n(rst_n), .soft_rst(1'b0), .enable(a_en),
        .baud_we(a_we), .baud_wdata(a_wdata), .baud_q(a_baud_q), .tick(a_tick),
        .srch_go(a_go), .srch_req(a_req), .srch_busy(a_busy), .srch_done(a_done),
        .srch_baud(a_sbaud), .srch_hz(a_shz)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
        end
    endtask

    // Expected search result, from the rate rule and scan order.
    function automatic void best_pair(input int unsigned rq, input int sh,
                                      output logic [7:0] b, output int unsigned hz);
        b  = 8'h44;
        hz = 0;
        for (int n = 0; n < 8; n++) begin
            for (int m = 0; m < 16; m++) begin
                int unsigned r;
                r = CLK_HZ / (10 * (m + 1) * (1 << (n + sh)));
                if (r <= rq && r > hz) begin
                    hz = r;
                    b  = {1'b0, 4'(m), 3'(n)};
                end
            end
        end
    endfunction

    // Edge counters: enabled edges since last tick, edges since search start.
    always @(posedge clk) begin
        en_q   = en;
        a_en_q = a_en;
        tcnt   = en ? tcnt + 1 : 0;
        acnt   = a_en ? acnt + 1 : 0;
        if (s_armed) scnt = scnt + 1;
    end

    // Tick monitor, main instance.
    always @(negedge clk) begin
        if (tick) begin
            if (!en_q) chk(1'b0, "R5", "tick while disabled", 1, 0);
            else if (tq.size() == 0) chk(1'b0, "R3", "unexpected tick", tcnt, 0);
            else begin
                tick_exp_t e;
                e = tq.pop_front();
                chk(tcnt == e.p, e.tag, "tick period", tcnt, e.p);
            end
            tcnt = 0;
        end
    end

    // Tick monitor, alternate-exponent instance.
    always @(negedge clk) begin
        if (a_tick) begin
            if (!a_en_q) chk(1'b0, "R10", "alt tick while disabled", 1, 0);
            else if (aq.size() == 0) chk(1'b0, "R10", "unexpected alt tick", acnt, 0);
            else begin
                tick_exp_t e;
                e = aq.pop_front();
                chk(acnt == e.p, e.tag, "alt tick period", acnt, e.p);
            end
            acnt = 0;
        end
    end

    // Search monitor: result and latency.
    always @(negedge clk) begin
        if (done) begin
            if (sq.size() == 0) chk(1'b0, "R8", "unexpected done", 1, 0);
            else begin
                srch_exp_t e;
                e = sq.pop_front();
                chk(sbaud == e.b, e.tag, "search byte", sbaud, e.b);
                chk(shz == e.hz, e.tag, "search rate", shz, e.hz);
                chk(scnt == 128, "R8", "search latency", scnt, 128);
            end
            s_armed = 1'b0;
        end
    end

    task automatic step(input int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic push_t(input int p, input string tag);
        tick_exp_t e;
        e.p = p; e.tag = tag;
        tq.push_back(e);
    endtask

    task automatic push_a(input int p, input string tag);
        tick_exp_t e;
        e.p = p; e.tag = tag;
        aq.push_back(e);
    endtask

    task automatic wr(input logic [7:0] v);
        we = 1'b1; wdata = v;
        step(1);
        we = 1'b0;
    endtask

    task automatic a_wr(input logic [7:0] v);
        a_we = 1'b1; a_wdata = v;
        step(1);
        a_we = 1'b0;
    endtask

    task automatic drain();
        while (tq.size() > 0 || aq.size() > 0 || sq.size() > 0) step(1);
    endtask

    task automatic search(input int unsigned rq, input string tag, input bit poke);
        srch_exp_t e;
        best_pair(rq, 1, e.b, e.hz);
        e.tag = tag;
        sq.push_back(e);
        req = rq; go = 1'b1;
        step(1);
        go = 1'b0; s_armed = 1'b1; scnt = 0;
        if (poke) begin
            step(10);
            req = 32'd1000; go = 1'b1;     // R8: ignored while busy
            step(1);
            go = 1'b0;
        end
        drain();
    endtask

    initial begin
        step(4);
        rst_n = 1'b1;
        step(1);
        // R1: reset state
        chk(baud_q == 8'h44, "R1", "reset byte", baud_q, 8'h44);
        chk(tick == 1'b0, "R1", "reset tick", tick, 0);
        chk(busy == 1'b0 && done == 1'b0, "R1", "reset search idle", busy, 0);
        chk(sbaud == 8'h44 && shz == 0, "R1", "reset search result", sbaud, 8'h44);

        // R5/R3: first period after enable, then steady period
        en = 1'b1;
        push_t(288, "R5"); push_t(288, "R3");
        drain();

        // R6: write while running; old period finishes first
        push_t(288, "R6");
        wr(8'h09);
        push_t(8, "R3"); push_t(8, "R3"); push_t(8, "R3");
        drain();

        // R2: top bit dropped, fields at 6:3 and 2:0
        push_t(8, "R6");
        wr(8'hFB);
        chk(baud_q == 8'h7B, "R2", "top bit dropped", baud_q, 8'h7B);
        push_t(256, "R2");
        drain();

        // R7/R4: write while disabled, shortest default period
        en = 1'b0;
        wr(8'h00);
        step(3);
        begin
            int seen;
            seen = 0;
            for (int i = 0; i < 20; i++) begin
                step(1);
                if (tick) seen++;
            end
            chk(seen == 0, "R5", "no tick while disabled", seen, 0);
        end
        en = 1'b1;
        push_t(2, "R7"); push_t(2, "R4"); push_t(2, "R4");
        drain();
        en = 1'b0;
        step(3);

        // R1: soft reset restores power-up byte and period
        soft_rst = 1'b1;
        step(1);
        soft_rst = 1'b0;
        chk(baud_q == 8'h44, "R1", "soft reset byte", baud_q, 8'h44);
        en = 1'b1;
        push_t(288, "R1");
        drain();
        en = 1'b0;
        step(2);

        // R8/R9: search cases
        search(32'd100_000, "R8", 1'b0);
        search(32'd400_000, "R8", 1'b1);
        search(32'd2_500_000, "R8", 1'b0);
        chk(sbaud == 8'h08, "R8", "tie keeps earlier pair", sbaud, 8'h08);
        search(32'd5_000_000, "R8", 1'b0);
        chk(sbaud == 8'h00, "R8", "fastest pair", sbaud, 8'h00);
        search(32'd1000, "R9", 1'b0);
        chk(sbaud == 8'h44 && shz == 0, "R9", "no fit keeps reset byte", sbaud, 8'h44);
        step(150);
        chk(busy == 1'b0, "R8", "idle after search", busy, 0);

        // R10: alternate exponent mode
        a_en = 1'b1;
        push_a(144, "R10"); push_a(144, "R10");
        drain();
        a_en = 1'b0;
        a_wr(8'h0A);
        step(3);
        a_en = 1'b1;
        push_a(8, "R10"); push_a(8, "R10");
        drain();
        a_en = 1'b0;
        begin
            logic [7:0]  eb;
            int unsigned eh;
            best_pair(32'd400_000, 0, eb, eh);
            a_req = 32'd400_000; a_go = 1'b1;
            step(1);
            a_go = 1'b0;
            step(128);
            chk(a_done == 1'b1, "R10", "alt search done", a_done, 1);
            chk(a_sbaud == eb, "R10", "alt search byte", a_sbaud, eb);
            chk(a_shz == eh, "R10", "alt search rate", a_shz, eh);
        end

        step(5);
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL R3 watchdog expired actual=%0d expected=%0d", 150000, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule